// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block follows the cache lines that one core touches while a hardware transaction runs, and it decides whether that transaction commits or aborts. The core sends begin, end and explicit-abort commands, and it tags loads and stores with their line address. Each load or store inside a transaction enters a small fully associative table. Every entry holds a line tag plus a "read" flag and a "written" flag. A line that is both read and written uses a single entry.

A snoop port carries remote coherence requests. Conflicts are detected eagerly:
- A remote request for exclusive ownership that hits any tracked line ends the transaction at once.
- A remote read that hits a written line also ends it at once.

A new line that finds the table full is a capacity abort, and so is a begin that would overflow the nesting counter. An interrupt during a transaction aborts it. Nesting is flat: inner begins and ends only move a depth counter, and only the outermost end commits.

When a commit happens, the whole write set is latched as a published mask in one edge and both sets are emptied. The published write-set lines can then be read out by entry index until the next outermost begin. A 16-bit status word records the outcome of the most recent transaction.

Top module: `txn_set_tracker`

## Requirements
- R1: While a transaction is active, a load sets the read flag of its line and a store sets the write flag. A line already tracked reuses its entry, and a new line takes the lowest free entry index. Because the table empties at every commit and abort, lines land at indices 0, 1, 2 … in order of first touch.
- R2: While active, a snoop with `snp_excl`=1 whose line matches any tracked entry (read or written) aborts the transaction. The status then has the conflict bit (bit 2) and the retry bit (bit 1) set.
- R3: While active, a snoop with `snp_excl`=0 aborts with conflict and retry bits only when its line matches an entry whose write flag is set. A remote read of a line that is only read does nothing.
- R4: An access to a line not yet tracked, while all ENTRIES entries are occupied, aborts with the capacity bit (bit 3). An access to a line already tracked never does.
- R5: An interrupt while active aborts with the interrupt bit (bit 4). An interrupt while idle has no effect.
- R6: An explicit abort command while active aborts with the explicit bit (bit 0) set and the 8-bit `cmd_code` placed in status bits 15:8. Every other cause leaves bits 15:8 at zero.
- R7: A begin increments the depth, and an end at depth above one decrements it. An end at depth one commits. A begin at the maximum depth (2^DEPTH_W−1) aborts with the capacity bit.
- R8: Any abort returns the depth to zero and empties both sets. The nested bit (bit 5) is set when the abort happens at a depth above one.
- R9: A commit publishes exactly the lines whose write flag is set, including a store accepted in the commit cycle. `ws_vld`/`ws_line` for index `ws_idx` show them from the next cycle until the next begin issued from depth zero, which clears them.
- R10: Among the explicit, conflict, capacity and interrupt bits, at most one is set. The retry bit appears only together with conflict, and bits 7:6 are zero. A commit clears the status to zero, and an abort overwrites it.
- R11: Loads, stores, snoops, ends, explicit aborts and interrupts issued at depth zero change nothing.
- R12: Within one cycle, the order of precedence is fixed:
  - Causes rank as snoop conflict, then interrupt, then capacity, then explicit abort. The snoop is matched against the sets as they stood before that cycle's access.
  - Commands rank as abort, then end, then begin. A lower-ranked command in the same cycle is ignored.
- R13: `commit_pulse` and `abort_pulse` are single-cycle pulses, never high together. Each rises on the clock edge that samples the causing inputs, and the status and depth change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_begin | input | 1 | Begin a transaction or one nesting level |
| cmd_end | input | 1 | End one nesting level |
| cmd_abort | input | 1 | Explicit abort request |
| cmd_code | input | 8 | Reason code for an explicit abort |
| acc_valid | input | 1 | Transactional load or store this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_line | input | LINE_W | Line address of the access |
| snp_valid | input | 1 | Remote coherence request this cycle |
| snp_excl | input | 1 | 1 = exclusive-ownership request, 0 = remote read |
| snp_line | input | LINE_W | Line address of the remote request |
| irq | input | 1 | Interrupt |
| ws_idx | input | IDX_W | Entry index for write-set readout |
| commit_pulse | output | 1 | One-cycle commit indication |
| abort_pulse | output | 1 | One-cycle abort indication |
| status | output | 16 | Outcome of the latest transaction |
| tx_active | output | 1 | Depth is non-zero |
| nest_depth | output | DEPTH_W | Current nesting depth |
| ws_line | output | LINE_W | Published line at `ws_idx` |
| ws_vld | output | 1 | Entry `ws_idx` holds a published write-set line |

## Verification
The bench builds the block with ENTRIES=4, DEPTH_W=2 and LINE_W=12. These sizes let a transaction fill the table in four accesses, so the capacity abort on a fifth new line comes within reach. They also make depth three the ceiling, where a further begin aborts. Against these parameters, a behavioural queue model predicts pulses, status, depth and the readout on every cycle. Directed sequences then place snoops, interrupts, commands and accesses in the same cycle to exercise each precedence rule.

// File: rtl/txn_pkg.sv
package txn_pkg;

  localparam int CODE_W = 8;

  // Outcome word, bit 0 at the bottom.
  typedef struct packed {
    logic [CODE_W-1:0] code;      // 15:8
    logic [1:0]        rsvd;      // 7:6
    logic              nested;    // 5
    logic              intr;      // 4
    logic              capacity;  // 3
    logic              conflict;  // 2
    logic              retry;     // 1
    logic              explicit_ab; // 0
  } txn_status_t;

  localparam int STATUS_W = $bits(txn_status_t);

endpackage

// File: rtl/txn_line_cam.sv
module txn_line_cam #(
  parameter int ENTRIES = 8,
  parameter int LINE_W  = 26,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  acc_line,
  input  logic               acc_wr,
  input  logic               acc_go,
  input  logic               clr,
  input  logic [LINE_W-1:0]  snp_line,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               snp_hit_any,
  output logic               snp_hit_wr,
  output logic               acc_ovf,
  output logic [ENTRIES-1:0] acc_sel,
  output logic [ENTRIES-1:0] wr_bits,
  output logic [LINE_W-1:0]  rd_line
);

  logic [LINE_W-1:0]  tag_q [ENTRIES];
  logic [ENTRIES-1:0] rd_q, wr_q, rd_n, wr_n;
  logic [ENTRIES-1:0] occ, hit_vec, snp_any_vec, snp_wr_vec, free_sel, tag_we;
  logic               acc_hit;

  assign occ = rd_q | wr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign hit_vec[g]     = occ[g]  && (tag_q[g] == acc_line);
    assign snp_any_vec[g] = occ[g]  && (tag_q[g] == snp_line);
    assign snp_wr_vec[g]  = wr_q[g] && (tag_q[g] == snp_line);
    assign tag_we[g]      = acc_go && !acc_hit && free_sel[g];

    always_ff @(posedge clk) begin
      if (tag_we[g]) tag_q[g] <= acc_line;
    end
  end

  // lowest free entry, one-hot
  always_comb begin
    free_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_sel    = '0;
        free_sel[i] = 1'b1;
      end
    end
  end

  assign acc_hit     = |hit_vec;
  assign acc_ovf     = !acc_hit && (&occ);
  assign acc_sel     = acc_hit ? hit_vec : free_sel;
  assign snp_hit_any = |snp_any_vec;
  assign snp_hit_wr  = |snp_wr_vec;
  assign wr_bits     = wr_q;
  assign rd_line     = (int'(rd_idx) < ENTRIES) ? tag_q[rd_idx] : '0;

  always_comb begin
    rd_n = rd_q;
    wr_n = wr_q;
    if (acc_go) begin
      if (acc_wr) wr_n = wr_q | acc_sel;
      else        rd_n = rd_q | acc_sel;
    end
    if (clr) begin
      rd_n = '0;
      wr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((rd_q | wr_q) == '0)); // R8

  AST_SETS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_go && !clr) |=> ($stable(rd_q) && $stable(wr_q))); // R11

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |-> ($countones(acc_sel) == 1)); // R1

endmodule

// File: rtl/txn_nest_ctl.sv
module txn_nest_ctl #(
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  input  logic               zero,
  output logic [DEPTH_W-1:0] depth,
  output logic               active,
  output logic               outer,
  output logic               deep,
  output logic               at_max
);

  localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q, depth_n;
  logic               depth_en;

  always_comb begin
    depth_en = zero || inc || dec;
    depth_n  = depth_q;
    if (zero)     depth_n = '0;
    else if (inc) depth_n = depth_q + ONE;
    else if (dec) depth_n = depth_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        depth_q <= '0;
    else if (depth_en) depth_q <= depth_n;
  end

  assign depth  = depth_q;
  assign active = (depth_q != '0);
  assign outer  = (depth_q == ONE);
  assign deep   = active && !outer;
  assign at_max = (depth_q == '1);

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !zero) |-> !at_max); // R7

  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !zero) |-> deep); // R7

endmodule

// File: rtl/txn_abort_arb.sv
module txn_abort_arb
  import txn_pkg::*;
(
  input  logic              active,
  input  logic              deep,
  input  logic              at_max,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic              snp_hit_any,
  input  logic              snp_hit_wr,
  input  logic              irq,
  input  logic              acc_valid,
  input  logic              acc_ovf,
  input  logic              sel_abort,
  input  logic              sel_begin,
  input  logic [CODE_W-1:0] code,
  output logic              abort_now,
  output txn_status_t       status_n
);

  logic snp_conf, irq_ab, cap_ab, exp_ab, nest_ab;

  always_comb begin
    snp_conf = active && snp_valid && (snp_excl ? snp_hit_any : snp_hit_wr);
    irq_ab   = active && irq && !snp_conf;
    cap_ab   = active && acc_valid && acc_ovf && !snp_conf && !irq_ab;
    exp_ab   = active && sel_abort && !snp_conf && !irq_ab && !cap_ab;
    nest_ab  = active && sel_begin && at_max && !snp_conf && !irq_ab && !cap_ab;
    abort_now = snp_conf || irq_ab || cap_ab || exp_ab || nest_ab;

    status_n             = '0;
    status_n.explicit_ab = exp_ab;
    status_n.retry       = snp_conf;
    status_n.conflict    = snp_conf;
    status_n.capacity    = cap_ab || nest_ab;
    status_n.intr        = irq_ab;
    status_n.nested      = deep;
    status_n.code        = exp_ab ? code : '0;
  end

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txn_pkg::*;
#(
  parameter  int ENTRIES = 8,
  parameter  int LINE_W  = 26,
  parameter  int DEPTH_W = 4,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_begin,
  input  logic               cmd_end,
  input  logic               cmd_abort,
  input  logic [7:0]         cmd_code,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [LINE_W-1:0]  acc_line,
  input  logic               snp_valid,
  input  logic               snp_excl,
  input  logic [LINE_W-1:0]  snp_line,
  input  logic               irq,
  input  logic [IDX_W-1:0]   ws_idx,
  output logic               commit_pulse,
  output logic               abort_pulse,
  output logic [15:0]        status,
  output logic               tx_active,
  output logic [DEPTH_W-1:0] nest_depth,
  output logic [LINE_W-1:0]  ws_line,
  output logic               ws_vld
);

  logic               active, outer, deep, at_max;
  logic [DEPTH_W-1:0] depth;
  logic               snp_hit_any, snp_hit_wr, acc_ovf;
  logic [ENTRIES-1:0] acc_sel, wr_bits;
  logic               sel_abort, sel_end, sel_begin;
  logic               abort_now, commit_now, acc_go;
  logic               nest_inc, nest_dec, sets_clr;
  txn_status_t        status_abort, status_q, status_n;
  logic               status_en;
  logic [ENTRIES-1:0] pub_q, pub_n;
  logic               pub_en;
  logic               commit_q, abort_q;

  // command ranking: abort over end over begin
  assign sel_abort = cmd_abort;
  assign sel_end   = cmd_end && !cmd_abort;
  assign sel_begin = cmd_begin && !cmd_end && !cmd_abort;

  txn_abort_arb u_arb (
    .active      (active),
    .deep        (deep),
    .at_max      (at_max),
    .snp_valid   (snp_valid),
    .snp_excl    (snp_excl),
    .snp_hit_any (snp_hit_any),
    .snp_hit_wr  (snp_hit_wr),
    .irq         (irq),
    .acc_valid   (acc_valid),
    .acc_ovf     (acc_ovf),
    .sel_abort   (sel_abort),
    .sel_begin   (sel_begin),
    .code        (cmd_code),
    .abort_now   (abort_now),
    .status_n    (status_abort)
  );

  assign acc_go     = active && acc_valid && !abort_now;
  assign commit_now = active && sel_end && outer && !abort_now;
  assign sets_clr   = abort_now || commit_now;
  assign nest_dec   = active && sel_end && !outer && !abort_now;
  assign nest_inc   = sel_begin && !at_max && !abort_now;

  txn_line_cam #(
    .ENTRIES (ENTRIES),
    .LINE_W  (LINE_W),
    .IDX_W   (IDX_W)
  ) u_cam (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_line    (acc_line),
    .acc_wr      (acc_write),
    .acc_go      (acc_go),
    .clr         (sets_clr),
    .snp_line    (snp_line),
    .rd_idx      (ws_idx),
    .snp_hit_any (snp_hit_any),
    .snp_hit_wr  (snp_hit_wr),
    .acc_ovf     (acc_ovf),
    .acc_sel     (acc_sel),
    .wr_bits     (wr_bits),
    .rd_line     (ws_line)
  );

  txn_nest_ctl #(
    .DEPTH_W (DEPTH_W)
  ) u_nest (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (nest_inc),
    .dec    (nest_dec),
    .zero   (sets_clr),
    .depth  (depth),
    .active (active),
    .outer  (outer),
    .deep   (deep),
    .at_max (at_max)
  );

  // next-state for status and published write set
  always_comb begin
    status_en = abort_now || commit_now;
    status_n  = abort_now ? status_abort : '0;

    pub_en = commit_now || (sel_begin && !active);
    pub_n  = '0;
    if (commit_now) pub_n = wr_bits | ((acc_go && acc_write) ? acc_sel : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pub_q    <= '0;
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      if (status_en) status_q <= status_n;
      if (pub_en)    pub_q    <= pub_n;
      commit_q <= commit_now;
      abort_q  <= abort_now;
    end
  end

  assign commit_pulse = commit_q;
  assign abort_pulse  = abort_q;
  assign status       = status_q;
  assign tx_active    = active;
  assign nest_depth   = depth;
  assign ws_vld       = (int'(ws_idx) < ENTRIES) ? pub_q[ws_idx] : 1'b0;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pulse && abort_pulse)); // R13

  AST_ABORT_DEPTH0: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (nest_depth == '0)); // R8

  AST_COMMIT_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> ($past(nest_depth) == DEPTH_W'(1))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> (!abort_pulse && !commit_pulse)); // R11

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[0], status[2], status[3], status[4]})); // R10

  AST_RETRY_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[2]); // R10

endmodule

// File: tb/txn_set_tracker_tb.sv
module txn_set_tracker_tb;

  localparam int N     = 4;
  localparam int LW    = 12;
  localparam int DW    = 2;
  localparam int IW    = 2;
  localparam int MAXD  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_begin, cmd_end, cmd_abort;
  logic [7:0]    cmd_code;
  logic          acc_valid, acc_write;
  logic [LW-1:0] acc_line;
  logic          snp_valid, snp_excl;
  logic [LW-1:0] snp_line;
  logic          irq;
  logic [IW-1:0] ws_idx;
  logic          commit_pulse, abort_pulse, tx_active, ws_vld;
  logic [15:0]   status;
  logic [DW-1:0] nest_depth;
  logic [LW-1:0] ws_line;

  always #10 clk = ~clk;

  txn_set_tracker #(.ENTRIES(N), .LINE_W(LW), .DEPTH_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_begin(cmd_begin), .cmd_end(cmd_end), .cmd_abort(cmd_abort), .cmd_code(cmd_code),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_line(acc_line),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_line(snp_line),
    .irq(irq), .ws_idx(ws_idx),
    .commit_pulse(commit_pulse), .abort_pulse(abort_pulse), .status(status),
    .tx_active(tx_active), .nest_depth(nest_depth), .ws_line(ws_line), .ws_vld(ws_vld)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string cur_req  = "R13";

  // behavioural reference
  int            mdepth;
  logic [15:0]   mstat;
  bit            mcommit, mabort;
  logic [LW-1:0] mq[$];
  bit            mwr[$];
  bit            pubv[N];
  logic [LW-1:0] publ[N];

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic mclear();
    mq.delete();
    mwr.delete();
  endtask

  task automatic model_step();
    bit act, snpc, irqa, capa, expa, nova, ab, selab, selend, selbeg;
    int hit;
    mcommit = 0;
    mabort  = 0;
    if (!rst_n) begin
      mdepth = 0; mstat = '0; mclear();
      for (int i = 0; i < N; i++) pubv[i] = 0;
      return;
    end
    act  = (mdepth > 0);
    snpc = 0;
    if (act && snp_valid)
      foreach (mq[i]) if (mq[i] == snp_line && (snp_excl || mwr[i])) snpc = 1;
    hit = -1;
    foreach (mq[i]) if (mq[i] == acc_line) hit = i;
    irqa   = act && irq && !snpc;
    capa   = act && acc_valid && hit < 0 && mq.size() == N && !snpc && !irqa;
    selab  = cmd_abort;
    selend = cmd_end && !cmd_abort;
    selbeg = cmd_begin && !cmd_end && !cmd_abort;
    expa   = act && selab && !snpc && !irqa && !capa;
    nova   = act && selbeg && mdepth == MAXD && !snpc && !irqa && !capa;
    ab     = snpc || irqa || capa || expa || nova;
    if (ab) begin
      mstat = {(expa ? cmd_code : 8'h00), 2'b00, (mdepth > 1), irqa, (capa || nova), snpc, snpc, expa};
      mclear();
      mdepth = 0;
      mabort = 1;
    end else begin
      if (act && acc_valid) begin
        if (hit < 0) begin
          mq.push_back(acc_line);
          mwr.push_back(acc_write);
        end else if (acc_write) mwr[hit] = 1;
      end
      if (act && selend) begin
        if (mdepth == 1) begin
          for (int i = 0; i < N; i++) pubv[i] = 0;
          foreach (mq[i]) if (mwr[i]) begin pubv[i] = 1; publ[i] = mq[i]; end
          mclear();
          mdepth = 0; mstat = '0; mcommit = 1;
        end else mdepth--;
      end else if (selbeg) begin
        if (mdepth == 0) for (int i = 0; i < N; i++) pubv[i] = 0;
        mdepth++;
      end
    end
  endtask

  task automatic compare();
    chk("commit_pulse", 32'(commit_pulse), 32'(mcommit));
    chk("abort_pulse", 32'(abort_pulse), 32'(mabort));
    chk("status", 32'(status), 32'(mstat));
    chk("nest_depth", 32'(nest_depth), 32'(mdepth));
    chk("tx_active", 32'(tx_active), 32'(mdepth > 0));
    chk("ws_vld", 32'(ws_vld), 32'(pubv[ws_idx]));
    if (pubv[ws_idx]) chk("ws_line", 32'(ws_line), 32'(publ[ws_idx]));
  endtask

  task automatic quiet();
    cmd_begin = 0; cmd_end = 0; cmd_abort = 0; cmd_code = '0;
    acc_valid = 0; acc_write = 0; acc_line = '0;
    snp_valid = 0; snp_excl = 0; snp_line = '0; irq = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    quiet();
  endtask

  task automatic sweep();
    for (int i = 0; i < N; i++) begin
      ws_idx = IW'(i);
      #1;
      chk("readout ws_vld", 32'(ws_vld), 32'(pubv[i]));
      if (pubv[i]) chk("readout ws_line", 32'(ws_line), 32'(publ[i]));
    end
    ws_idx = '0;
  endtask

  task automatic ld(logic [LW-1:0] a);  acc_valid = 1; acc_write = 0; acc_line = a; tick(); endtask
  task automatic st(logic [LW-1:0] a);  acc_valid = 1; acc_write = 1; acc_line = a; tick(); endtask
  task automatic tbeg();                cmd_begin = 1; tick(); endtask
  task automatic tend();                cmd_end = 1; tick(); endtask
  task automatic snp(bit ex, logic [LW-1:0] a); snp_valid = 1; snp_excl = ex; snp_line = a; tick(); endtask

  initial begin
    quiet();
    ws_idx = '0;
    rst_n  = 0;
    @(negedge clk);
    tick();
    rst_n = 1;
    cur_req = "R10 reset";
    tick();

    // R11: idle traffic is ignored
    cur_req = "R11";
    ld(12'h111); st(12'h222); snp(1, 12'h111); irq = 1; tick();
    tend(); cmd_abort = 1; cmd_code = 8'h33; tick();
    tbeg(); tend(); sweep();

    // R1: read/write tracking and entry order
    cur_req = "R1";
    tbeg(); ld(12'h0A0); st(12'h0B0); ld(12'h0B0); st(12'h0C0); st(12'h0A0);
    tend(); sweep();

    // R9: store in commit cycle, readout survives idle, cleared by begin
    cur_req = "R9";
    tbeg(); ld(12'h010); acc_valid = 1; acc_write = 1; acc_line = 12'h020; cmd_end = 1; tick();
    sweep(); ld(12'h030); st(12'h040); sweep();
    tbeg(); sweep(); tend();

    // R2: exclusive snoop hitting read set and write set
    cur_req = "R2";
    tbeg(); ld(12'h100); snp(1, 12'h101); snp(1, 12'h100);
    tbeg(); st(12'h200); snp(1, 12'h200);

    // R3: remote read only conflicts with written lines
    cur_req = "R3";
    tbeg(); ld(12'h300); snp(0, 12'h300); st(12'h310); snp(0, 12'h310);

    // R4: capacity
    cur_req = "R4";
    tbeg(); ld(12'h400); ld(12'h401); st(12'h402); ld(12'h403);
    st(12'h401); ld(12'h400); ld(12'h404);

    // R5: interrupt
    cur_req = "R5";
    tbeg(); ld(12'h500); irq = 1; tick(); irq = 1; tick();

    // R6: explicit abort with code
    cur_req = "R6";
    tbeg(); st(12'h600); cmd_abort = 1; cmd_code = 8'hA5; tick();

    // R7: nesting and depth ceiling
    cur_req = "R7";
    tbeg(); tbeg(); tbeg(); tbeg();
    tbeg(); tbeg(); st(12'h700); tend(); tend(); sweep();

    // R8: nested abort
    cur_req = "R8";
    tbeg(); tbeg(); cmd_abort = 1; cmd_code = 8'h5C; tick();
    tbeg(); tbeg(); snp_valid = 0; irq = 1; tick();

    // R12: same-cycle ordering
    cur_req = "R12";
    tbeg(); st(12'h800);
    snp_valid = 1; snp_excl = 0; snp_line = 12'h810; acc_valid = 1; acc_write = 1; acc_line = 12'h810; tick();
    snp_valid = 1; snp_excl = 1; snp_line = 12'h800; irq = 1; cmd_abort = 1; cmd_code = 8'h11; tick();
    tbeg(); ld(12'h820); ld(12'h821); ld(12'h822); ld(12'h823);
    acc_valid = 1; acc_line = 12'h824; cmd_abort = 1; cmd_code = 8'h22; tick();
    tbeg(); irq = 1; cmd_abort = 1; cmd_code = 8'h44; tick();
    tbeg(); cmd_end = 1; cmd_begin = 1; tick();
    tbeg(); cmd_abort = 1; cmd_end = 1; cmd_code = 8'h66; tick();

    // R13: back-to-back pulses
    cur_req = "R13";
    tbeg(); tend(); tbeg(); irq = 1; tick(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R13 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule